// File: doc/BRIEF.md
# Line-Cycle Four-Point Noise Rejector

This block removes mains-frequency interference from the conversion results of up to eight multiplexed input channels. A channel is meant to be sampled four times in each mains period, a quarter period apart. Samples half a period apart then carry line noise of equal size and opposite sign. The block keeps the four most recent samples of every channel in a small register array. On each new sample it replaces that channel's oldest entry and produces the sum of the four entries, so the line component cancels. It also produces the sum divided by four.

A free-running quadrant timer derives the quarter-period strobe from the master clock. A mode input selects 60 Hz or 50 Hz mains, which gives 240 or 200 strobes per second at the nominal clock. A result is marked usable only after four fresh samples have entered the channel since reset or since that channel was cleared. The upstream sequencer clears a channel whenever it reconfigures it.

Top module: `lnr_line_rejector`

## Requirements
- R1: A synchronous active-high `rst` empties every entry of the array and clears every fill count, `chan_ready`, `res_stb`, `res_ok`, `quad_tick` and `quad_idx`. A sample taken after reset is therefore summed only with zeros.
- R2: `quad_tick` pulses for one cycle every CLK_HZ/240 clocks when `line_sel`=0 (60 Hz) and every CLK_HZ/200 clocks when `line_sel`=1 (50 Hz). The first pulse after reset comes that many clocks after reset is released.
- R3: `quad_idx` steps by one, modulo 4, with each `quad_tick`. A change of `line_sel` restarts the timer: in the following cycle `quad_idx` is 0 and no tick is present, and the next tick comes one full quarter period of the new mode later.
- R4: An accepted sample overwrites the oldest of the four entries of its own channel. The entries of other channels are not changed.
- R5: One cycle after an accepted sample, `res_stb` is high for one cycle. In that cycle `res_chan` holds the sample's channel and `res_sum` holds the two's-complement sum of that channel's four entries, including the new sample. `res_sum` is two bits wider than the input, so it never overflows.
- R6: `res_avg` equals `res_sum` shifted right arithmetically by two, which rounds toward minus infinity.
- R7: `res_ok` and `chan_ready[c]` are 1 only once channel c has taken at least four samples since reset or since its last clear.
- R8: `clr_stb` with `clr_chan` zeroes that channel's entries, write position and fill count. The other channels keep their state.
- R9: If `smp_stb` and `clr_stb` name the same channel in the same cycle, the clear takes effect, the sample is discarded and no `res_stb` follows. If they name different channels, both take effect.
- R10: Consider four consecutive samples of one channel in which a component appears again, negated, two samples later. That component contributes nothing to `res_sum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sel | input | 1 | Mains mode: 0 = 60 Hz, 1 = 50 Hz |
| smp_stb | input | 1 | Sample strobe |
| smp_chan | input | CW (3) | Channel of the sample |
| smp_data | input | W (16) | Signed sample word |
| clr_stb | input | 1 | Channel clear strobe (sent on reconfiguration) |
| clr_chan | input | CW (3) | Channel to clear |
| quad_tick | output | 1 | Quarter-period strobe |
| quad_idx | output | 2 | Current quadrant number |
| res_stb | output | 1 | Result strobe |
| res_ok | output | 1 | Result uses four fresh samples |
| res_chan | output | CW (3) | Channel of the result |
| res_sum | output | W+2 (18) | Signed four-entry sum |
| res_avg | output | W (16) | Signed sum divided by four |
| chan_ready | output | NCH (8) | Per-channel four-samples-present flags |

## Verification
The two functions that can land in the same cycle are a channel clear and a sample write. The bench drives both strobes in one cycle, first aimed at the same channel and then at two different channels. It judges the outcome from `res_stb`, `res_chan`, `res_sum` and `chan_ready`, and from the sum the next sample of the cleared channel produces. A second overlap is a mains-mode change arriving while the quadrant counter runs. The bench checks that `quad_idx` restarts at zero and measures the clock count to the next tick.

// File: rtl/lnr_pkg.sv
package lnr_pkg;

  typedef enum logic {
    LINE_60HZ = 1'b0,
    LINE_50HZ = 1'b1
  } line_mode_e;

  localparam int unsigned LNR_TAPS = 4;

  // clocks in one quarter of a mains period for the given mode
  function automatic int unsigned quarter_clocks(input int unsigned clk_hz,
                                                 input line_mode_e    mode);
    int unsigned per_sec;
    per_sec = (mode == LINE_50HZ) ? 4 * 50 : 4 * 60;
    return clk_hz / per_sec;
  endfunction

endpackage

// File: rtl/lnr_quad_timer.sv
module lnr_quad_timer
  import lnr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3686400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_sel,
  output logic       quad_tick,
  output logic [1:0] quad_idx,
  output logic       mode_restart
);

  localparam int unsigned Q60  = quarter_clocks(CLK_HZ, LINE_60HZ);
  localparam int unsigned Q50  = quarter_clocks(CLK_HZ, LINE_50HZ);
  localparam int unsigned QMAX = (Q50 > Q60) ? Q50 : Q60;
  localparam int unsigned CNTW = $clog2(QMAX + 1);

  line_mode_e            mode_q;
  logic [CNTW-1:0]       cnt;
  logic [CNTW-1:0]       lim;
  logic                  wrap;

  assign lim          = (mode_q == LINE_50HZ) ? CNTW'(Q50 - 1) : CNTW'(Q60 - 1);
  assign mode_restart = (line_mode_e'(line_sel) != mode_q);
  assign wrap         = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= line_mode_e'(line_sel);
      cnt       <= '0;
      quad_tick <= 1'b0;
      quad_idx  <= 2'd0;
    end else if (mode_restart) begin
      mode_q    <= line_mode_e'(line_sel);
      cnt       <= '0;
      quad_tick <= 1'b0;
      quad_idx  <= 2'd0;
    end else if (wrap) begin
      cnt       <= '0;
      quad_tick <= 1'b1;
      quad_idx  <= quad_idx + 2'd1;
    end else begin
      cnt       <= cnt + CNTW'(1);
      quad_tick <= 1'b0;
    end
  end

  a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
    quad_tick |-> quad_idx == $past(quad_idx) + 2'd1);

  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    quad_tick |=> !quad_tick);

  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    mode_restart |=> (quad_idx == 2'd0) && !quad_tick);

endmodule

// File: rtl/lnr_chan_store.sv
module lnr_chan_store
  import lnr_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [CW-1:0]              wr_chan,
  input  logic signed [W-1:0]        wr_data,
  input  logic                       clr_en,
  input  logic [CW-1:0]              clr_chan,
  output logic [LNR_TAPS*W-1:0]      nxt_taps,
  output logic                       nxt_full,
  output logic [NCH-1:0]             ready
);

  localparam int TW = LNR_TAPS * W;

  logic [TW-1:0] taps_cur [NCH];
  logic [1:0]    ptr_cur  [NCH];
  logic [2:0]    fill_cur [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic signed [W-1:0] ent [LNR_TAPS];
    logic [1:0]          ptr;
    logic [2:0]          fill;
    logic                hit_clr;
    logic                hit_wr;

    assign hit_clr = clr_en && (clr_chan == CW'(c));
    assign hit_wr  = wr_en && (wr_chan == CW'(c));

    always_ff @(posedge clk) begin
      if (rst || hit_clr) begin
        for (int t = 0; t < LNR_TAPS; t++) ent[t] <= '0;
        ptr  <= 2'd0;
        fill <= 3'd0;
      end else if (hit_wr) begin
        ent[ptr] <= wr_data;
        ptr      <= ptr + 2'd1;
        fill     <= (fill == 3'd4) ? 3'd4 : fill + 3'd1;
      end
    end

    for (genvar t = 0; t < LNR_TAPS; t++) begin : g_pack
      assign taps_cur[c][t*W +: W] = ent[t];
    end
    assign ptr_cur[c]  = ptr;
    assign fill_cur[c] = fill;
    assign ready[c]    = (fill == 3'd4);

    a_r7_fill_bound: assert property (@(posedge clk) disable iff (rst)
      fill <= 3'd4);

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
      (hit_wr && !hit_clr) |=> ptr == $past(ptr) + 2'd1);
  end

  // entries of the addressed channel as they stand after the write
  always_comb begin
    nxt_taps = taps_cur[wr_chan];
    nxt_taps[int'(ptr_cur[wr_chan]) * W +: W] = wr_data;
    nxt_full = (fill_cur[wr_chan] >= 3'd3);
  end

endmodule

// File: rtl/lnr_sum_out.sv
module lnr_sum_out
  import lnr_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld,
  input  logic [CW-1:0]          ld_chan,
  input  logic [LNR_TAPS*W-1:0]  taps,
  input  logic                   ld_full,
  output logic                   res_stb,
  output logic                   res_ok,
  output logic [CW-1:0]          res_chan,
  output logic signed [W+1:0]    res_sum,
  output logic signed [W-1:0]    res_avg
);

  localparam int SW = W + 2;

  function automatic logic signed [SW-1:0] tap_sum(input logic [LNR_TAPS*W-1:0] v);
    logic signed [SW-1:0] acc;
    logic        [W-1:0]  s;
    acc = '0;
    for (int i = 0; i < LNR_TAPS; i++) begin
      s   = v[i*W +: W];
      acc = acc + $signed({{2{s[W-1]}}, s});
    end
    return acc;
  endfunction

  function automatic logic signed [W-1:0] quarter_of(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] sh;
    sh = v >>> 2;
    return sh[W-1:0];
  endfunction

  logic signed [SW-1:0] sum_d;
  assign sum_d = tap_sum(taps);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_stb  <= 1'b0;
      res_ok   <= 1'b0;
      res_chan <= '0;
      res_sum  <= '0;
      res_avg  <= '0;
    end else begin
      res_stb <= ld;
      if (ld) begin
        res_ok   <= ld_full;
        res_chan <= ld_chan;
        res_sum  <= sum_d;
        res_avg  <= quarter_of(sum_d);
      end
    end
  end

  a_r5_stb_pulse_src: assert property (@(posedge clk) disable iff (rst)
    res_stb |-> $past(ld));

endmodule

// File: rtl/lnr_line_rejector.sv
module lnr_line_rejector
  import lnr_pkg::*;
#(
  parameter int          W      = 16,
  parameter int          NCH    = 8,
  parameter int unsigned CLK_HZ = 3686400,
  localparam int         CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_sel,
  input  logic                 smp_stb,
  input  logic [CW-1:0]        smp_chan,
  input  logic signed [W-1:0]  smp_data,
  input  logic                 clr_stb,
  input  logic [CW-1:0]        clr_chan,
  output logic                 quad_tick,
  output logic [1:0]           quad_idx,
  output logic                 res_stb,
  output logic                 res_ok,
  output logic [CW-1:0]        res_chan,
  output logic signed [W+1:0]  res_sum,
  output logic signed [W-1:0]  res_avg,
  output logic [NCH-1:0]       chan_ready
);

  logic                  smp_drop;
  logic                  smp_take;
  logic                  mode_restart;
  logic [LNR_TAPS*W-1:0] nxt_taps;
  logic                  nxt_full;

  assign smp_drop = smp_stb && clr_stb && (smp_chan == clr_chan);
  assign smp_take = smp_stb && !smp_drop;

  lnr_quad_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .line_sel     (line_sel),
    .quad_tick    (quad_tick),
    .quad_idx     (quad_idx),
    .mode_restart (mode_restart)
  );

  lnr_chan_store #(.W(W), .NCH(NCH), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (smp_take),
    .wr_chan  (smp_chan),
    .wr_data  (smp_data),
    .clr_en   (clr_stb),
    .clr_chan (clr_chan),
    .nxt_taps (nxt_taps),
    .nxt_full (nxt_full),
    .ready    (chan_ready)
  );

  lnr_sum_out #(.W(W), .CW(CW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .ld       (smp_take),
    .ld_chan  (smp_chan),
    .taps     (nxt_taps),
    .ld_full  (nxt_full),
    .res_stb  (res_stb),
    .res_ok   (res_ok),
    .res_chan (res_chan),
    .res_sum  (res_sum),
    .res_avg  (res_avg)
  );

  a_r5_follow: assert property (@(posedge clk) disable iff (rst)
    smp_take |=> res_stb && (res_chan == $past(smp_chan)));

  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    smp_drop |=> !res_stb);

  a_r7_ok_ready: assert property (@(posedge clk) disable iff (rst)
    (res_stb && res_ok) |-> chan_ready[res_chan]);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> !chan_ready[$past(clr_chan)]);

endmodule

// File: tb/sim_lnr_line_rejector.sv
module sim_lnr_line_rejector;

  localparam int          W      = 16;
  localparam int          NCH    = 8;
  localparam int unsigned CLK_HZ = 24000;
  localparam int          QP60   = CLK_HZ / 240;
  localparam int          QP50   = CLK_HZ / 200;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 line_sel = 1'b0;
  logic                 smp_stb = 1'b0;
  logic [2:0]           smp_chan = '0;
  logic signed [W-1:0]  smp_data = '0;
  logic                 clr_stb = 1'b0;
  logic [2:0]           clr_chan = '0;
  logic                 quad_tick;
  logic [1:0]           quad_idx;
  logic                 res_stb;
  logic                 res_ok;
  logic [2:0]           res_chan;
  logic signed [W+1:0]  res_sum;
  logic signed [W-1:0]  res_avg;
  logic [NCH-1:0]       chan_ready;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lnr_line_rejector #(.W(W), .NCH(NCH), .CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .line_sel(line_sel),
    .smp_stb(smp_stb), .smp_chan(smp_chan), .smp_data(smp_data),
    .clr_stb(clr_stb), .clr_chan(clr_chan),
    .quad_tick(quad_tick), .quad_idx(quad_idx),
    .res_stb(res_stb), .res_ok(res_ok), .res_chan(res_chan),
    .res_sum(res_sum), .res_avg(res_avg), .chan_ready(chan_ready)
  );

  // {chan[37:35], data[34:19], expected sum[18:1], expected ok[0]}
  localparam logic [37:0] VEC [12] = '{
    {3'd2, 16'd1300,  18'd1300,   1'b0},
    {3'd2, 16'd1200,  18'd2500,   1'b0},
    {3'd5, 16'h8000,  18'h38000,  1'b0},
    {3'd2, 16'd700,   18'd3200,   1'b0},
    {3'd2, 16'd800,   18'd4000,   1'b1},
    {3'd5, 16'h8000,  18'h30000,  1'b0},
    {3'd5, 16'h8000,  18'h28000,  1'b0},
    {3'd5, 16'h8000,  18'h20000,  1'b1},
    {3'd2, 16'd1300,  18'd4000,   1'b1},
    {3'd2, 16'hFFFB,  18'd2795,   1'b1},
    {3'd5, 16'h7FFF,  18'h2FFFF,  1'b1},
    {3'd2, 16'hFFFD,  18'd2092,   1'b1}
  };

  // division by four rounding toward minus infinity
  function automatic int floor_quarter(input int s);
    if (s >= 0) return s / 4;
    return -((-s + 3) / 4);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic send(input logic [2:0] ch, input logic signed [W-1:0] d);
    smp_chan = ch; smp_data = d; smp_stb = 1'b1;
    @(posedge clk); #1;
    smp_stb = 1'b0;
  endtask

  task automatic both(input logic [2:0] sc, input logic signed [W-1:0] d,
                      input logic [2:0] cc);
    smp_chan = sc; smp_data = d; smp_stb = 1'b1;
    clr_chan = cc; clr_stb = 1'b1;
    @(posedge clk); #1;
    smp_stb = 1'b0; clr_stb = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!quad_tick);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin : main
    int n;
    int es;
    logic [1:0] idx0;

    do_reset();
    // R1 reset state
    chk("R1", "chan_ready", int'(chan_ready), 0);
    chk("R1", "res_stb", int'(res_stb), 0);
    chk("R1", "quad_idx", int'(quad_idx), 0);
    chk("R1", "quad_tick", int'(quad_tick), 0);

    // R2 60 Hz quarter period, from reset release and between ticks
    wait_tick(n);
    chk("R2", "first tick after reset", n, QP60);
    chk("R3", "idx after first tick", int'(quad_idx), 1);
    idx0 = quad_idx;
    wait_tick(n);
    chk("R2", "60Hz tick spacing", n, QP60);
    chk("R3", "idx step", int'(quad_idx), int'(idx0 + 2'd1));

    // R3 mode change restarts timer, R2 50 Hz spacing
    repeat (7) @(posedge clk);
    #1 line_sel = 1'b1;
    @(posedge clk); #1;
    chk("R3", "idx after mode change", int'(quad_idx), 0);
    chk("R3", "no tick after mode change", int'(quad_tick), 0);
    wait_tick(n);
    chk("R3", "restart to first 50Hz tick", n, QP50);
    wait_tick(n);
    chk("R2", "50Hz tick spacing", n, QP50);

    // vector table: R4 R5 R6 R7 R10
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][37:35], VEC[i][34:19]);
      es = int'($signed(VEC[i][18:1]));
      chk("R5", $sformatf("vec%0d res_stb", i), int'(res_stb), 1);
      chk("R5", $sformatf("vec%0d res_chan", i), int'(res_chan), int'(VEC[i][37:35]));
      chk("R4/R10", $sformatf("vec%0d res_sum", i), int'(res_sum), es);
      chk("R6", $sformatf("vec%0d res_avg", i), int'(res_avg), floor_quarter(es));
      chk("R7", $sformatf("vec%0d res_ok", i), int'(res_ok), int'(VEC[i][0]));
    end
    @(posedge clk); #1;
    chk("R5", "strobe lasts one cycle", int'(res_stb), 0);
    chk("R7", "ready ch2/ch5", int'(chan_ready), 8'b0010_0100);

    // R8 clear one channel only
    clr_chan = 3'd2; clr_stb = 1'b1;
    @(posedge clk); #1 clr_stb = 1'b0;
    chk("R8", "ready after clear ch2", int'(chan_ready), 8'b0010_0000);
    send(3'd2, 16'sd100);
    chk("R8", "sum after clear", int'(res_sum), 100);
    chk("R8", "ok after clear", int'(res_ok), 0);
    send(3'd5, 16'sd0);
    chk("R8", "ch5 entries kept", int'(res_sum), -65537 + 32768);

    // R9 same channel: clear wins, sample dropped
    both(3'd5, 16'sd9, 3'd5);
    chk("R9", "no strobe on collision", int'(res_stb), 0);
    chk("R9", "ch5 cleared", int'(chan_ready[5]), 0);
    send(3'd5, 16'sd4);
    chk("R9", "dropped sample absent", int'(res_sum), 4);
    // R9 different channels: both act
    both(3'd5, 16'sd7, 3'd2);
    chk("R9", "strobe on split", int'(res_stb), 1);
    chk("R9", "split chan", int'(res_chan), 5);
    chk("R9", "split sum", int'(res_sum), 11);
    send(3'd2, 16'sd3);
    chk("R9", "ch2 cleared on split", int'(res_sum), 3);

    // R5/R7 largest positive sum without overflow
    for (int k = 0; k < 4; k++) send(3'd7, 16'sd32767);
    chk("R5", "max sum", int'(res_sum), 131068);
    chk("R6", "max avg", int'(res_avg), 32767);
    chk("R7", "ready ch7", int'(chan_ready[7]), 1);

    // R1 reset mid-run empties the array
    do_reset();
    chk("R1", "ready after reset", int'(chan_ready), 0);
    send(3'd7, 16'sd50);
    chk("R1", "sum after reset", int'(res_sum), 50);
    chk("R1", "ok after reset", int'(res_ok), 0);

    finish_up();
  end

endmodule